// File: doc/BRIEF.md
# Framed Bit-Error-Rate Checker

This block sits at the receive end of a radio link test. The far end transmits a framed test pattern without pause. Each frame is a one-byte alignment marker of value 0xAA followed by thirty-two payload bytes that count upward from 0x00 to 0x1F. The block receives that stream as a serial data line together with the recovered bit clock. It locks onto each frame by spotting the marker, rebuilds the expected payload bit by bit, and keeps two running totals: payload bits compared and payload bits in error.

Alignment is renewed on every frame, so a slip or a damaged frame costs at most one frame of counts. When an operator presses the request button, both totals are frozen into a pair of display registers. An external unit turns those figures into a ratio and drives the digits from them. A clear input zeroes the running totals so that a fresh measurement can start.

Top module: `ber_checker`

## Requirements
- R1: After reset both display outputs read zero and the block is searching for a marker.
- R2: The marker is found when the last eight received bits, oldest in the most significant position, equal 0xAA. The 256 bits that follow it are treated as payload.
- R3: Payload byte k is expected to hold the value k, sent most significant bit first. Every payload bit adds one to the bit total, and every payload bit that differs from its expected value also adds one to the error total.
- R4: Marker bits are never counted. A frame whose marker is damaged (for example 0xAB) is skipped entirely, and counting resumes with the next intact frame.
- R5: Frames that follow one another with no idle gap are all counted.
- R6: A payload byte that happens to equal 0xAA does not restart alignment. The rest of that frame and the next frame are counted normally, and the altered byte counts as many errors as the bits it has flipped.
- R7: Each total is CNT_W bits wide and stops at its all-ones value instead of wrapping.
- R8: Asserting the clear input zeroes both running totals on the next clock edge, and clear takes priority over counting in that cycle.
- R9: A rising edge on the request input copies both running totals into the display outputs. At all other times the display outputs hold their values.
- R10: When request and clear rise in the same cycle, the display receives the totals as they stood before the clear.
- R11: The data line is sampled at the rising edge of the recovered clock. Both lines pass through a two-stage synchronizer in the system clock domain, and each clock phase must last at least three system clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxClk | input | 1 | Recovered bit clock from the radio |
| rxData | input | 1 | Serial received data |
| reqBtn | input | 1 | Operator request; a rising edge captures the totals |
| clrCnt | input | 1 | Synchronous clear of the running totals |
| shownBits | output | CNT_W | Captured total of compared payload bits |
| shownErrs | output | CNT_W | Captured total of errored payload bits |

## Verification
Assertions check the following on every cycle:
- the error total never exceeds the bit total;
- counters move by exactly one step or stay pinned at their maximum;
- nothing is counted outside a payload bit;
- clear empties both totals;
- the display holds between requests;
- an in-frame 0xAA never ends checking early.

Only the bench scenarios can show whether the numbers are right. These include:
- clean, randomly corrupted and back-to-back frames;
- a payload byte turned into 0xAA;
- a damaged marker;
- saturation on a narrow instance;
- a clear and a request that arrive together.

// File: rtl/ber_pkg.sv
package ber_pkg;

  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_CHECK = 1'b1
  } berState_t;

  // control to datapath strobes
  typedef struct packed {
    logic       bitStb;   // a new serial bit is available
    logic       bitVal;   // its value
    logic       cmpEn;    // this bit belongs to the payload
    logic [7:0] expByte;  // expected payload byte
    logic [2:0] bitIdx;   // position inside the byte, 0 = MSB
    logic       snap;     // capture totals for display
    logic       clr;      // zero the running totals
  } berStrobe_t;

endpackage

// File: rtl/ber_satcnt.sv
module ber_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       cnt <= '0;
    else if (clr)                    cnt <= '0;
    else if (inc && cnt != CNT_MAX)  cnt <= cnt + W'(1);
  end

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> cnt == '0);

  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inc && !clr && cnt != CNT_MAX) |=> cnt == $past(cnt) + W'(1));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);

endmodule

// File: rtl/ber_ctrl.sv
module ber_ctrl
  import ber_pkg::*;
#(
  parameter int DATA_BYTES = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxClk,
  input  logic       rxData,
  input  logic       reqBtn,
  input  logic       clrCnt,
  input  logic       markerHit,
  output berStrobe_t strb
);
  localparam int IDX_W = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(DATA_BYTES - 1);

  logic [SYNC_DEPTH:0]   clkPipe;
  logic [SYNC_DEPTH-1:0] datPipe;
  logic                  reqQ;
  berState_t             state;
  logic [IDX_W-1:0]      byteIdx;
  logic [2:0]            bitIdx;
  logic                  bitStb;
  logic                  lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe <= '0;
      datPipe <= '0;
      reqQ    <= 1'b0;
    end else begin
      clkPipe <= {clkPipe[SYNC_DEPTH-1:0], rxClk};
      datPipe <= {datPipe[SYNC_DEPTH-2:0], rxData};
      reqQ    <= reqBtn;
    end
  end

  assign bitStb  = clkPipe[SYNC_DEPTH-1] & ~clkPipe[SYNC_DEPTH];
  assign lastBit = (byteIdx == LAST_BYTE) && (bitIdx == 3'd7);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      byteIdx <= '0;
      bitIdx  <= '0;
    end else if (bitStb) begin
      unique case (state)
        ST_HUNT: begin
          if (markerHit) begin
            state   <= ST_CHECK;
            byteIdx <= '0;
            bitIdx  <= '0;
          end
        end
        ST_CHECK: begin
          bitIdx <= bitIdx + 3'd1;
          if (bitIdx == 3'd7)
            byteIdx <= lastBit ? '0 : byteIdx + IDX_W'(1);
          if (lastBit)
            state <= ST_HUNT;
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  always_comb begin
    strb.bitStb  = bitStb;
    strb.bitVal  = datPipe[SYNC_DEPTH-1];
    strb.cmpEn   = bitStb && (state == ST_CHECK);
    strb.expByte = 8'(byteIdx);
    strb.bitIdx  = bitIdx;
    strb.snap    = reqBtn & ~reqQ;
    strb.clr     = clrCnt;
  end

  assert_lock_on_marker_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HUNT && bitStb && markerHit) |=>
      (state == ST_CHECK && byteIdx == '0 && bitIdx == 3'd0));

  assert_payload_uninterrupted_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && bitStb && !lastBit) |=> state == ST_CHECK);

  assert_frame_end_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && bitStb && lastBit) |=> state == ST_HUNT);

endmodule

// File: rtl/ber_datapath.sv
module ber_datapath
  import ber_pkg::*;
#(
  parameter int         CNT_W  = 32,
  parameter logic [7:0] MARKER = 8'hAA
) (
  input  logic             clk,
  input  logic             rstN,
  input  berStrobe_t       strb,
  output logic             markerHit,
  output logic [CNT_W-1:0] shownBits,
  output logic [CNT_W-1:0] shownErrs
);
  localparam int N_CNT = 2;  // 0: compared bits, 1: errored bits

  logic [7:0]       window;
  logic             expBit;
  logic [N_CNT-1:0] incVec;
  logic [CNT_W-1:0] cntArr [N_CNT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            window <= '0;
    else if (strb.bitStb) window <= {window[6:0], strb.bitVal};
  end

  assign markerHit = strb.bitStb && ({window[6:0], strb.bitVal} == MARKER);
  assign expBit    = strb.expByte[3'd7 - strb.bitIdx];
  assign incVec[0] = strb.cmpEn;
  assign incVec[1] = strb.cmpEn && (strb.bitVal != expBit);

  for (genvar g = 0; g < N_CNT; g++) begin : g_tally
    ber_satcnt #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rstN (rstN),
      .clr  (strb.clr),
      .inc  (incVec[g]),
      .cnt  (cntArr[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shownBits <= '0;
      shownErrs <= '0;
    end else if (strb.snap) begin
      shownBits <= cntArr[0];
      shownErrs <= cntArr[1];
    end
  end

  assert_errs_within_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    cntArr[1] <= cntArr[0]);

  assert_idle_no_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cmpEn && !strb.clr) |=> ($stable(cntArr[0]) && $stable(cntArr[1])));

  assert_display_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.snap |=> ($stable(shownBits) && $stable(shownErrs)));

endmodule

// File: rtl/ber_checker.sv
module ber_checker
  import ber_pkg::*;
#(
  parameter int         CNT_W      = 32,
  parameter int         DATA_BYTES = 32,
  parameter int         SYNC_DEPTH = 2,
  parameter logic [7:0] MARKER     = 8'hAA
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxClk,
  input  logic             rxData,
  input  logic             reqBtn,
  input  logic             clrCnt,
  output logic [CNT_W-1:0] shownBits,
  output logic [CNT_W-1:0] shownErrs
);
  berStrobe_t strb;
  logic       markerHit;

  ber_ctrl #(
    .DATA_BYTES (DATA_BYTES),
    .SYNC_DEPTH (SYNC_DEPTH)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rxClk     (rxClk),
    .rxData    (rxData),
    .reqBtn    (reqBtn),
    .clrCnt    (clrCnt),
    .markerHit (markerHit),
    .strb      (strb)
  );

  ber_datapath #(
    .CNT_W  (CNT_W),
    .MARKER (MARKER)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .markerHit (markerHit),
    .shownBits (shownBits),
    .shownErrs (shownErrs)
  );

endmodule

// File: tb/tb_ber_checker.sv
module tb_ber_checker;

  localparam int SAT_W   = 10;
  localparam int SAT_MAX = (1 << SAT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxClk = 1'b0;
  logic rxData = 1'b0;
  logic reqBtn = 1'b0;
  logic clrCnt = 1'b0;
  logic [31:0]      shownBits, shownErrs;
  logic [SAT_W-1:0] satBits, satErrs;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  longint expBits = 0;
  longint expErrs = 0;

  always #10 clk = ~clk;

  ber_checker dut (
    .clk(clk), .rstN(rstN), .rxClk(rxClk), .rxData(rxData),
    .reqBtn(reqBtn), .clrCnt(clrCnt),
    .shownBits(shownBits), .shownErrs(shownErrs)
  );

  ber_checker #(.CNT_W(SAT_W)) dutSat (
    .clk(clk), .rstN(rstN), .rxClk(rxClk), .rxData(rxData),
    .reqBtn(reqBtn), .clrCnt(clrCnt),
    .shownBits(satBits), .shownErrs(satErrs)
  );

  function automatic int ones8(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic longint satTo(input longint v, input longint mx);
    return (v > mx) ? mx : v;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk) rxData = b;
    repeat (4) @(negedge clk);
    rxClk = 1'b1;
    repeat (4) @(negedge clk);
    rxClk = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
  endtask

  // rate: 0 none, 1 flip all, n flip with probability 1/n; last byte never flipped
  task automatic sendFrame(input logic [7:0] mk, input int rate,
                           input int subIdx, input logic [7:0] subVal,
                           output int errs);
    logic [7:0] v, mask;
    errs = 0;
    sendByte(mk);
    for (int k = 0; k < 32; k++) begin
      mask = 8'h00;
      if (rate > 0 && k < 31)
        for (int i = 0; i < 8; i++)
          if (($urandom % rate) == 0) mask[i] = 1'b1;
      v = 8'(k) ^ mask;
      if (k == subIdx) v = subVal;
      errs += ones8(v ^ 8'(k));
      sendByte(v);
    end
  endtask

  task automatic request();
    @(negedge clk) reqBtn = 1'b1;
    @(negedge clk) reqBtn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic goodFrames(input int n, input int rate);
    int e;
    for (int f = 0; f < n; f++) begin
      sendFrame(8'hAA, rate, -1, 8'h00, e);
      expBits += 256;
      expErrs += e;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int e;
    longint holdB, holdE;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check("R1 shownBits after reset", shownBits, 0);
    check("R1 shownErrs after reset", shownErrs, 0);

    // R2: leading idle bytes contain no marker; R11 sampling on rxClk rise
    sendByte(8'h00); sendByte(8'hFF); sendByte(8'h00);
    request();
    check("R2 nothing counted before marker", shownBits, 0);

    // R5 back-to-back clean frames, R11 sampling
    goodFrames(3, 0);
    request();
    check("R5 R11 bits after clean frames", shownBits, expBits);
    check("R3 no errors on clean frames", shownErrs, expErrs);

    // R3 random corruption
    goodFrames(4, 16);
    request();
    check("R3 bits with random errors", shownBits, expBits);
    check("R3 errors with random errors", shownErrs, expErrs);

    // R6 payload byte equal to 0xAA
    sendFrame(8'hAA, 0, 5, 8'hAA, e);
    check("R6 bench error tally for 0xAA byte", e, 6);
    expBits += 256; expErrs += e;
    goodFrames(1, 0);
    request();
    check("R6 bits after in-payload 0xAA", shownBits, expBits);
    check("R6 errors after in-payload 0xAA", shownErrs, expErrs);

    // R4 damaged marker skips frame; marker never counted
    sendFrame(8'hAB, 0, -1, 8'h00, e);
    goodFrames(1, 0);
    request();
    check("R4 damaged-marker frame skipped", shownBits, expBits);
    check("R4 errors unchanged by skipped frame", shownErrs, expErrs);

    // R9 display holds while new frames arrive
    holdB = shownBits; holdE = shownErrs;
    goodFrames(1, 0);
    check("R9 shownBits held without request", shownBits, holdB);
    check("R9 shownErrs held without request", shownErrs, holdE);

    // R7 saturation on narrow instance
    goodFrames(5, 1);
    request();
    check("R3 bits after full corruption", shownBits, expBits);
    check("R3 errors after full corruption", shownErrs, expErrs);
    check("R7 saturated bit total", satBits, satTo(expBits, SAT_MAX));
    check("R7 saturated error total", satErrs, satTo(expErrs, SAT_MAX));

    // R10 clear and request together
    @(negedge clk) begin reqBtn = 1'b1; clrCnt = 1'b1; end
    @(negedge clk) begin reqBtn = 1'b0; clrCnt = 1'b0; end
    repeat (2) @(negedge clk);
    check("R10 display keeps pre-clear bits", shownBits, expBits);
    check("R10 display keeps pre-clear errs", shownErrs, expErrs);
    expBits = 0; expErrs = 0;
    request();
    check("R8 bits zero after clear", shownBits, 0);
    check("R8 errs zero after clear", shownErrs, 0);

    // R8 counting resumes after clear
    goodFrames(2, 8);
    request();
    check("R8 bits after clear and frames", shownBits, expBits);
    check("R8 errs after clear and frames", shownErrs, expErrs);
    check("R7 narrow instance below limit", satBits, satTo(expBits, SAT_MAX));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule